// File: doc/BRIEF.md
# Synchronous Burst Access Sequencer

This block is the clocked control path for burst transfers on a pseudo-static RAM slave. It samples chip enable, address-valid, write enable and the address on each rising clock edge. When it sees a capture cycle, it records the start address and the direction. It then counts the initial latency and steps through the burst one word per clock, producing the array word address and a read or write strobe for each beat. It also drives a WAIT output that tells the bus master when data is about to move.

A configuration source outside the block supplies the following static fields:
- the burst-length code;
- the wrap enable;
- the latency code;
- the fixed/variable latency select;
- the WAIT lead option;
- the WAIT polarity.

An array refresh engine raises `refresh_busy` while an internal refresh is in progress. The DRAM array, the data pins, asynchronous and page accesses, and the output drivers all sit outside this block. The `wait_oe` output is the enable for an external three-state WAIT buffer.

Top module: `burst_access_seq`

## Requirements
- R1: A rising edge with `ce_n`=0 and `adv_n`=0 while idle captures `addr_i` and the direction. `we_n`=1 selects a read: beats drive `rd_stb`=1 and `dq_oe`=1. `we_n`=0 selects a write: beats drive `wr_stb`=1 and `dq_oe`=0.
- R2: `cfg_len` selects the burst length: 3'b001 gives 4 words, 3'b010 gives 8, 3'b011 gives 16 and 3'b100 gives 32. Every other code is continuous, which runs until the beat at column 255 (`arr_addr[7:0]`=8'hFF, rows are 256 words) and then stops.
- R3: With `cfg_wrap`=1 and a fixed length N, the address advances modulo N inside the N-aligned block that holds the start address. In continuous mode `cfg_wrap` has no effect.
- R4: Without wrapping, when a beat at column 255 is not the last beat, one stall cycle follows. In that cycle WAIT is asserted and there is no strobe. The burst then continues at the next address, which rolls over at the top of the address space.
- R5: The latency code is clamped to the range 2..6 to give L. For a variable-latency read, WAIT is asserted for L cycles after the capture edge, and the first beat occupies the cycle after the L-th following rising edge.
- R6: With `cfg_fixed`=1, and for every write, the latency is 2*L cycles.
- R7: During a variable-latency read, `refresh_busy`=1 holds the sequencer in latency, with WAIT asserted, until the first edge that samples it low. Fixed-latency reads and writes ignore `refresh_busy`.
- R8: With `cfg_wait_lead`=1, WAIT shows in each cycle the asserted state of the following cycle. With `cfg_wait_lead`=0, it shows the state of the current cycle.
- R9: With `cfg_wait_pol`=1, an asserted WAIT is driven high. With `cfg_wait_pol`=0, it is driven low. `wait_oe` equals the inverse of `ce_n`.
- R10: `ce_n`=1 drops `dq_oe` at once. From the next edge the sequencer is idle, with no strobes, and a new capture is needed to start another burst.
- R11: While the clock is held low, the current beat's address and strobe stay unchanged. The next rising edge advances to the following beat.
- R12: Under reset the block is idle, with `rd_stb`=0, `wr_stb`=0, `dq_oe`=0 and `arr_addr`=0.
- R13: In the cycle after the last beat there is no strobe and WAIT is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; held low to suspend a burst |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Direction at capture: 1 read, 0 write |
| addr_i | input | ADDR_W | Word address sampled at capture |
| cfg_len | input | 3 | Burst length code |
| cfg_wrap | input | 1 | Wrap within burst length |
| cfg_lat | input | 3 | Latency code |
| cfg_fixed | input | 1 | 1 selects fixed latency for reads |
| cfg_wait_lead | input | 1 | 1 makes WAIT lead data by one clock |
| cfg_wait_pol | input | 1 | 1 selects active-high WAIT |
| refresh_busy | input | 1 | Internal refresh in progress |
| arr_addr | output | ADDR_W | Word address of the current beat |
| rd_stb | output | 1 | Read beat strobe |
| wr_stb | output | 1 | Write beat strobe |
| dq_oe | output | 1 | Data output enable during read beats |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT buffer enable |

## Verification
The bench builds the block with `ADDR_W`=10, which gives four rows of 256 words. With that width, crossing from column 255 of one row into the next row is easy to reach from short bursts, and so is the rollover from 10'h3FF to 10'h000. A table of bursts covers every length code, wrapping and sequential stepping, clamped latency codes and write latency. Directed tests then cover the WAIT lead and polarity options, refresh collisions in each latency mode, abort by chip enable and clock suspension in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int COL_W   = 8;   // 256-word row
  localparam int BEAT_W  = 6;   // holds the longest fixed burst (32)
  localparam int LAT_W   = 4;   // holds twice the largest latency code
  localparam int BLK_LSB = 5;   // address bits above the largest wrap block

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_XFER = 2'd2,
    ST_ROW  = 2'd3
  } seq_state_e;

  // Latency in cycles: clamp code to 2..6, double it for fixed mode.
  function automatic logic [LAT_W-1:0] lat_cycles(input logic [2:0] code,
                                                  input logic       fixed_mode);
    logic [LAT_W-1:0] c;
    if (code < 3'd2)      c = LAT_W'(2);
    else if (code > 3'd6) c = LAT_W'(6);
    else                  c = LAT_W'(code);
    return fixed_mode ? LAT_W'(c << 1) : c;
  endfunction

  // Words per burst; zero means run to end of row.
  function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] code);
    case (code)
      3'b001:  return BEAT_W'(4);
      3'b010:  return BEAT_W'(8);
      3'b011:  return BEAT_W'(16);
      3'b100:  return BEAT_W'(32);
      default: return '0;
    endcase
  endfunction

  // Next column inside an aligned block of 'beats' words.
  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0]  col,
                                                input logic [BEAT_W-1:0] beats);
    logic [COL_W-1:0] m;
    m = COL_W'(beats) - COL_W'(1);
    return (col & ~m) | ((col + COL_W'(1)) & m);
  endfunction
endpackage

// File: rtl/bseq_lat_ctr.sv
module bseq_lat_ctr
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val - LAT_W'(1);
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - LAT_W'(1);
  end

  assign done = (cnt_q == '0);

  // R5: the count rests at zero while latency is held
  p_lat_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && done) |=> done);
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BEAT_W-1:0] beats,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              final_beat,
  output logic              need_stall
);
  logic [BEAT_W-1:0] beat_q, beats_q;
  logic              wrap_q, wrap_act, last_beat;
  logic [ADDR_W-1:0] addr_n;

  assign wrap_act   = wrap_q && (beats_q != '0);
  assign row_end    = &addr[COL_W-1:0];
  assign last_beat  = (beats_q != '0) && (beat_q == beats_q - BEAT_W'(1));
  assign final_beat = last_beat || ((beats_q == '0) && row_end);
  assign need_stall = row_end && !wrap_act && !final_beat;
  assign addr_n     = wrap_act ? {addr[ADDR_W-1:COL_W], wrap_col(addr[COL_W-1:0], beats_q)}
                               : addr + ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      beat_q  <= '0;
      beats_q <= '0;
      wrap_q  <= 1'b0;
    end else if (start) begin
      addr    <= start_addr;
      beat_q  <= '0;
      beats_q <= beats;
      wrap_q  <= wrap_en;
    end else if (step) begin
      addr    <= addr_n;
      beat_q  <= beat_q + BEAT_W'(1);
    end
  end

  // R3: a wrapping step never leaves its aligned block
  p_wrap_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_act) |=> (addr[ADDR_W-1:BLK_LSB] == $past(addr[ADDR_W-1:BLK_LSB])));

  // R4: a sequential step off column 255 lands on column 0
  p_row_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && need_stall) |=> (addr[COL_W-1:0] == '0));
endmodule

// File: rtl/bseq_wait_drv.sv
module bseq_wait_drv (
  input  logic ce_n,
  input  logic wait_now,
  input  logic wait_next,
  input  logic lead,
  input  logic pol,
  output logic wait_o,
  output logic wait_oe
);
  logic asserted;

  assign asserted = lead ? wait_next : wait_now;
  assign wait_oe  = !ce_n;
  assign wait_o   = wait_oe && (asserted ? pol : !pol);
endmodule

// File: rtl/burst_access_seq.sv
module burst_access_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_wrap,
  input  logic [2:0]        cfg_lat,
  input  logic              cfg_fixed,
  input  logic              cfg_wait_lead,
  input  logic              cfg_wait_pol,
  input  logic              refresh_busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              dq_oe,
  output logic              wait_o,
  output logic              wait_oe
);
  seq_state_e state_q, state_n;
  logic       wr_q, var_rd_q;
  logic       start, step, lat_done, ref_hold;
  logic       row_end, final_beat, need_stall;
  logic       wait_now, wait_next;

  // named internal events
  assign start    = (state_q == ST_IDLE) && !ce_n && !adv_n;
  assign step     = (state_q == ST_XFER);
  assign ref_hold = var_rd_q && refresh_busy;

  always_comb begin
    state_n = state_q;
    if (ce_n) state_n = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (start) state_n = ST_LAT;
        ST_LAT:  if (lat_done && !ref_hold) state_n = ST_XFER;
        ST_XFER: if (final_beat)      state_n = ST_IDLE;
                 else if (need_stall) state_n = ST_ROW;
        ST_ROW:  state_n = ST_XFER;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      var_rd_q <= 1'b0;
    end else begin
      state_q <= state_n;
      if (start) begin
        wr_q     <= !we_n;
        var_rd_q <= we_n && !cfg_fixed;
      end
    end
  end

  bseq_lat_ctr u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (lat_cycles(cfg_lat, cfg_fixed || !we_n)),
    .run      (state_q == ST_LAT),
    .done     (lat_done)
  );

  bseq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (step),
    .start_addr (addr_i),
    .beats      (beats_of(cfg_len)),
    .wrap_en    (cfg_wrap),
    .addr       (arr_addr),
    .row_end    (row_end),
    .final_beat (final_beat),
    .need_stall (need_stall)
  );

  assign wait_now  = (state_q == ST_LAT) || (state_q == ST_ROW);
  assign wait_next = (state_n == ST_LAT) || (state_n == ST_ROW);

  bseq_wait_drv u_wait (
    .ce_n      (ce_n),
    .wait_now  (wait_now),
    .wait_next (wait_next),
    .lead      (cfg_wait_lead),
    .pol       (cfg_wait_pol),
    .wait_o    (wait_o),
    .wait_oe   (wait_oe)
  );

  assign rd_stb = (state_q == ST_XFER) && !wr_q;
  assign wr_stb = (state_q == ST_XFER) && wr_q;
  assign dq_oe  = rd_stb && !ce_n;

  // R1: a capture cycle always enters latency
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !ce_n && !adv_n) |=> (state_q == ST_LAT));

  // R10: deselect ends any burst at the next edge
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (state_q == ST_IDLE && !rd_stb && !wr_stb));

  // R7: a variable read colliding with refresh stays in latency
  p_refresh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAT && !ce_n && refresh_busy && var_rd_q) |=> (state_q == ST_LAT));

  // R4: a row stall lasts exactly one cycle
  p_row_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROW && !ce_n) |=> (state_q == ST_XFER));
endmodule

// File: tb/burst_access_seq_tb_top.sv
module burst_access_seq_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  always #5 clk = clk_run ? ~clk : 1'b0;

  logic rst_n, ce_n, adv_n, we_n;
  logic [AW-1:0] addr_i;
  logic [2:0] cfg_len, cfg_lat;
  logic cfg_wrap, cfg_fixed, cfg_wait_lead, cfg_wait_pol, refresh_busy;
  logic [AW-1:0] arr_addr;
  logic rd_stb, wr_stb, dq_oe, wait_o, wait_oe;

  burst_access_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .addr_i(addr_i), .cfg_len(cfg_len), .cfg_wrap(cfg_wrap), .cfg_lat(cfg_lat),
    .cfg_fixed(cfg_fixed), .cfg_wait_lead(cfg_wait_lead), .cfg_wait_pol(cfg_wait_pol),
    .refresh_busy(refresh_busy), .arr_addr(arr_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe));

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;

  // {len[2:0], wrap, lat[2:0], fixed, write, addr[9:0]}
  localparam logic [18:0] VECS [7] = '{
    {3'b001, 1'b1, 3'd3, 1'b0, 1'b0, 10'h0A6},
    {3'b010, 1'b0, 3'd2, 1'b0, 1'b1, 10'h0FD},
    {3'b011, 1'b1, 3'd4, 1'b1, 1'b0, 10'h13E},
    {3'b100, 1'b0, 3'd5, 1'b0, 1'b0, 10'h2F0},
    {3'b111, 1'b1, 3'd2, 1'b0, 1'b0, 10'h1F8},
    {3'b101, 1'b0, 3'd7, 1'b0, 1'b1, 10'h0FC},
    {3'b001, 1'b0, 3'd0, 1'b1, 1'b0, 10'h3FE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] len, input logic wrap, input logic [2:0] lat,
                         input logic fixed, input logic lead, input logic pol);
    cfg_len = len; cfg_wrap = wrap; cfg_lat = lat; cfg_fixed = fixed;
    cfg_wait_lead = lead; cfg_wait_pol = pol;
  endtask

  // Returns at the sampling point of the first cycle after the capture edge.
  task automatic start_burst(input logic [AW-1:0] a, input logic wr);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; we_n = !wr; addr_i = a;
    @(posedge clk);
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  task automatic end_burst();
    ce_n = 1'b1; adv_n = 1'b1;
    @(negedge clk);
  endtask

  // Latency cycles with WAIT asserted (active high), then the first beat.
  task automatic expect_first_beat(input int ncyc, input logic wr, input string req);
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) @(negedge clk);
      chk(req, 32'(wait_o), 32'd1);
      chk(req, 32'(rd_stb | wr_stb), 32'd0);
    end
    @(negedge clk);
    chk(req, 32'(wr ? wr_stb : rd_stb), 32'd1);
  endtask

  task automatic run_vec(input logic [18:0] v);
    logic [2:0] len, lat;
    logic wrap, fixed, wr;
    logic [AW-1:0] a, m;
    int lc, lcyc, n;
    string lreq, areq;
    len = v[18:16]; wrap = v[15]; lat = v[14:12]; fixed = v[11]; wr = v[10]; a = v[9:0];
    set_cfg(len, wrap, lat, fixed, 1'b0, 1'b1);
    refresh_busy = 1'b0;
    lc   = (lat < 3'd2) ? 2 : ((lat > 3'd6) ? 6 : int'(lat));
    lcyc = (fixed || wr) ? 2 * lc : lc;
    lreq = (fixed || wr) ? "R6" : "R5";
    case (len)
      3'b001: n = 4;  3'b010: n = 8;  3'b011: n = 16;  3'b100: n = 32;
      default: n = 0;
    endcase
    areq = (wrap && n != 0) ? "R3" : "R2";
    m = AW'(n - 1);
    start_burst(a, wr);
    for (int i = 0; i < lcyc; i++) begin
      if (i > 0) @(negedge clk);
      chk(lreq, 32'(wait_o), 32'd1);
      chk(lreq, 32'(rd_stb | wr_stb), 32'd0);
    end
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      chk("R1", 32'(wr ? wr_stb : rd_stb), 32'd1);
      chk("R1", 32'(dq_oe), 32'(!wr));
      chk(areq, 32'(arr_addr), 32'(a));
      if ((n != 0 && k == n - 1) || (n == 0 && a[7:0] == 8'hFF)) break;
      if (wrap && n != 0) a = (a & ~m) | ((a + AW'(1)) & m);
      else begin
        if (a[7:0] == 8'hFF) begin
          @(negedge clk);
          chk("R4", 32'(wait_o), 32'd1);
          chk("R4", 32'(rd_stb | wr_stb), 32'd0);
        end
        a = a + AW'(1);
      end
    end
    @(negedge clk);
    chk("R13", 32'(rd_stb | wr_stb), 32'd0);
    chk("R13", 32'(wait_o), 32'd0);
    end_burst();
    chk("R9", 32'(wait_oe), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; addr_i = '0;
    refresh_busy = 1'b0;
    set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R12", 32'(rd_stb), 32'd0);
    chk("R12", 32'(wr_stb), 32'd0);
    chk("R12", 32'(dq_oe), 32'd0);
    chk("R12", 32'(arr_addr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", 32'(wait_oe), 32'd0);

    for (int v = 0; v < 7; v++) run_vec(VECS[v]);

    // R8: one-clock lead
    set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; addr_i = 10'h020;
    #1 chk("R8", 32'(wait_o), 32'd1);
    @(posedge clk); @(negedge clk); adv_n = 1'b1;
    chk("R8", 32'(wait_o), 32'd1);
    @(negedge clk);
    chk("R8", 32'(wait_o), 32'd0);
    chk("R8", 32'(rd_stb), 32'd0);
    @(negedge clk);
    chk("R8", 32'(rd_stb), 32'd1);
    chk("R8", 32'(arr_addr), 32'h020);
    end_burst();

    // R9: active-low WAIT, then abort (R10)
    set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
    start_burst(10'h030, 1'b0);
    chk("R9", 32'(wait_o), 32'd0);
    chk("R9", 32'(wait_oe), 32'd1);
    @(negedge clk);
    chk("R9", 32'(wait_o), 32'd0);
    @(negedge clk);
    chk("R9", 32'(wait_o), 32'd1);
    chk("R9", 32'(rd_stb), 32'd1);
    ce_n = 1'b1;
    #1 chk("R9", 32'(wait_oe), 32'd0);
    chk("R10", 32'(dq_oe), 32'd0);
    @(negedge clk);
    chk("R10", 32'(rd_stb), 32'd0);

    // R7: refresh collisions
    set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1);
    refresh_busy = 1'b1;
    start_burst(10'h050, 1'b0);
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7", 32'(wait_o), 32'd1);
      chk("R7", 32'(rd_stb), 32'd0);
    end
    refresh_busy = 1'b0;
    @(negedge clk);
    chk("R7", 32'(rd_stb), 32'd1);
    chk("R7", 32'(arr_addr), 32'h050);
    end_burst();
    set_cfg(3'b001, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1);
    refresh_busy = 1'b1;
    start_burst(10'h060, 1'b0);
    expect_first_beat(4, 1'b0, "R7");
    end_burst();
    cfg_fixed = 1'b0;
    start_burst(10'h070, 1'b1);
    expect_first_beat(4, 1'b1, "R7");
    end_burst();
    refresh_busy = 1'b0;

    // R10: abort during latency, no restart without capture
    set_cfg(3'b010, 1'b0, 3'd6, 1'b0, 1'b0, 1'b1);
    start_burst(10'h090, 1'b0);
    chk("R10", 32'(wait_o), 32'd1);
    @(negedge clk);
    ce_n = 1'b1;
    #1 chk("R10", 32'(wait_oe), 32'd0);
    @(negedge clk);
    chk("R10", 32'(rd_stb), 32'd0);
    ce_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R10", 32'(rd_stb | wr_stb), 32'd0);
    end
    end_burst();
    cfg_lat = 3'd2;
    start_burst(10'h080, 1'b0);
    expect_first_beat(2, 1'b0, "R10");
    chk("R10", 32'(arr_addr), 32'h080);
    end_burst();

    // R11: clock suspension
    start_burst(10'h040, 1'b0);
    expect_first_beat(2, 1'b0, "R11");
    @(negedge clk);
    chk("R11", 32'(arr_addr), 32'h041);
    clk_run = 1'b0;
    #50;
    chk("R11", 32'(arr_addr), 32'h041);
    chk("R11", 32'(rd_stb), 32'd1);
    clk_run = 1'b1;
    @(negedge clk);
    chk("R11", 32'(arr_addr), 32'h042);
    chk("R11", 32'(rd_stb), 32'd1);
    end_burst();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule